// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on an incoming master clock and watches a frame clock sampled in that domain. It counts master-clock cycles between successive rising frame edges and sorts each count into one of four ratio classes: 256, 384, 512 or 768 cycles per frame. It declares the clocks usable only when two back-to-back frame periods fall in the same class. While the clocks are usable, it produces a clock-enable strobe. Downstream logic that advances only on that strobe then runs at exactly 256 steps per frame, whichever ratio arrived. For 384 cycles per frame the strobe keeps two of every three master cycles. For 512 it keeps every second cycle, and for 768 every third.

The valid flag is the power-down release for the rest of the design. It stays low after reset and after any loss of the frame clock until a fresh, consistent measurement exists. An active-low power-down input discards all measurement history at any time. The relative phase of the two clocks and the frame clock's high time play no part: only rising-edge spacing counts.

The block carries no data path. The ratio code, the enable strobe and the valid flag are plain level or strobe outputs with no handshake, so back-pressure does not apply. A consumer that is not ready for a step simply sees the next strobe later.

Top module: `mclk_ratio_detect`

## Requirements
- R1: After reset, clk_valid, en_256 and ratio_code are all 0, and they stay 0 until a lock occurs.
- R2: When pdn_n is sampled low, clk_valid is 0 from the next cycle and all history is dropped. After release, three fresh rising frame edges are needed before clk_valid rises.
- R3: A frame period is the number of master cycles from one rising frame edge to the next. It falls in a class when it is within ±2 of that class's nominal count. The nominals and codes are 256 → code 0, 384 → code 1, 512 → code 2 and 768 → code 3. A period in no window (for example 259) never produces a lock.
- R4: clk_valid rises in the cycle after the rising edge that closes the second consecutive period in one class, and ratio_code then shows that class. The first edge after reset, power-down or timeout only starts the measurement.
- R5: A period outside every window, or in a different window from the period before it, makes clk_valid low from the cycle after the edge that closes it.
- R6: With code 0 and clk_valid high, en_256 is high every cycle.
- R7: With code 1, en_256 follows the repeating pattern high, high, low, starting at the first valid cycle. This gives 256 strobes per 384-cycle frame.
- R8: With code 2, en_256 alternates high, low, starting high at the first valid cycle.
- R9: With code 3, en_256 follows high, low, low, starting at the first valid cycle.
- R10: If 1024 master cycles pass with no rising frame edge, clk_valid falls and the measurement restarts, so three new edges are needed to lock.
- R11: en_256 is never high while clk_valid is low, and ratio_code does not change while clk_valid stays high.
- R12: The frame clock's high time has no effect on detection or on the strobe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down request, synchronous clear |
| frame_in | input | 1 | Frame clock, already sampled in the master-clock domain |
| ratio_code | output | 2 | Detected class: 0=256, 1=384, 2=512, 3=768 cycles per frame |
| en_256 | output | 1 | Strobe giving 256 enables per frame while valid |
| clk_valid | output | 1 | Clocks consistent; releases downstream power-down |

## Verification
The bench drives every nominal period with different frame high times, so any dependence on duty or phase becomes visible. It also drives periods two cycles off nominal, which must still lock, and a period three cycles off (259), which must never lock. These patterns separate the window edges from the class decision. Counting strobes over a whole locked frame shows that each decimation pattern yields exactly 256. A sudden switch from 256 to 512 checks that a class change drops the lock before any relock. A silent frame clock and a power-down pulse each check that three new edges are needed afterwards.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  localparam int NUM_CLASSES = 4;

  // Nominal master cycles per frame for class k, scaled from the base rate.
  function automatic int class_nominal(input int base, input int k);
    case (k)
      0:       return base;
      1:       return base + base / 2;
      2:       return 2 * base;
      default: return 3 * base;
    endcase
  endfunction

  // Length of the repeating enable pattern for a class, minus one.
  function automatic logic [1:0] pattern_last(input ratio_e r);
    case (r)
      RATIO_256: return 2'd0;
      RATIO_384: return 2'd2;
      RATIO_512: return 2'd1;
      default:   return 2'd2;
    endcase
  endfunction

  // Whether the enable is asserted at a given phase of the pattern.
  function automatic logic pattern_hit(input ratio_e r, input logic [1:0] ph);
    case (r)
      RATIO_256: return 1'b1;
      RATIO_384: return (ph != 2'd2);
      default:   return (ph == 2'd0);
    endcase
  endfunction

endpackage

// File: rtl/mcr_period_meter.sv
module mcr_period_meter #(
  parameter int TIMEOUT = 1024,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             frame_in,
  output logic             period_vld,
  output logic [CNT_W-1:0] period,
  output logic             timeout
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

  logic             frame_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise       = frame_in & ~frame_q;
  assign period_vld = rise & seen_q & ~clr;
  assign period     = cnt_q + CNT_W'(1);
  assign timeout    = ~rise & (cnt_q == LIMIT) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
    end else begin
      frame_q <= frame_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (rise) begin
      seen_q <= 1'b1;
      cnt_q  <= '0;
    end else if (cnt_q == LIMIT) begin
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mcr_ratio_lock.sv
module mcr_ratio_lock
  import mcr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int BASE  = 256,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             period_vld,
  input  logic [CNT_W-1:0] period,
  input  logic             timeout,
  output logic             valid,
  output ratio_e           code
);

  logic [NUM_CLASSES-1:0] hit;
  logic                   cls_ok;
  ratio_e                 cls;
  logic                   prev_ok_q;
  ratio_e                 prev_cls_q;
  logic                   valid_q;
  ratio_e                 code_q;

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_window
    localparam int NOM = class_nominal(BASE, k);
    localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
    assign hit[k] = (period >= LO) && (period <= HI);
  end

  always_comb begin
    cls = RATIO_256;
    for (int k = 0; k < NUM_CLASSES; k++) begin
      if (hit[k]) cls = ratio_e'(2'(k));
    end
  end

  assign cls_ok = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ok_q  <= 1'b0;
      prev_cls_q <= RATIO_256;
      valid_q    <= 1'b0;
      code_q     <= RATIO_256;
    end else if (clr) begin
      prev_ok_q  <= 1'b0;
      prev_cls_q <= RATIO_256;
      valid_q    <= 1'b0;
      code_q     <= RATIO_256;
    end else if (timeout) begin
      prev_ok_q  <= 1'b0;
      valid_q    <= 1'b0;
    end else if (period_vld) begin
      prev_ok_q  <= cls_ok;
      prev_cls_q <= cls;
      if (cls_ok && prev_ok_q && (cls == prev_cls_q)) begin
        valid_q <= 1'b1;
        code_q  <= cls;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid = valid_q;
  assign code  = code_q;

endmodule

// File: rtl/mcr_rate_enable.sv
module mcr_rate_enable
  import mcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   valid,
  input  ratio_e code,
  output logic   en
);

  logic [1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 2'd0;
    end else if (clr || !valid) begin
      ph_q <= 2'd0;
    end else if (ph_q == pattern_last(code)) begin
      ph_q <= 2'd0;
    end else begin
      ph_q <= ph_q + 2'd1;
    end
  end

  assign en = valid & pattern_hit(code, ph_q);

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mcr_pkg::*;
#(
  parameter int BASE    = 256,
  parameter int TOL     = 2,
  parameter int TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdn_n,
  input  logic       frame_in,
  output logic [1:0] ratio_code,
  output logic       en_256,
  output logic       clk_valid
);

  localparam int CNT_W = $clog2(TIMEOUT) + 1;

  logic             clr;
  logic             period_vld;
  logic [CNT_W-1:0] period;
  logic             timeout;
  logic             valid;
  ratio_e           code;

  assign clr = ~pdn_n;

  mcr_period_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .frame_in   (frame_in),
    .period_vld (period_vld),
    .period     (period),
    .timeout    (timeout)
  );

  mcr_ratio_lock #(.CNT_W(CNT_W), .BASE(BASE), .TOL(TOL)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .period_vld (period_vld),
    .period     (period),
    .timeout    (timeout),
    .valid      (valid),
    .code       (code)
  );

  mcr_rate_enable u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .valid (valid),
    .code  (code),
    .en    (en_256)
  );

  assign ratio_code = code;
  assign clk_valid  = valid;

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
  parameter int TIMEOUT = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pdn_n,
  input logic       frame_in,
  input logic [1:0] ratio_code,
  input logic       en_256,
  input logic       clk_valid
);

  logic        fq;
  logic [11:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq  <= 1'b0;
      gap <= '0;
    end else begin
      fq <= frame_in;
      if (frame_in && !fq) gap <= '0;
      else if (gap != 12'hfff) gap <= gap + 12'd1;
    end
  end

  assert_pdn_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |=> !clk_valid);

  assert_no_stray_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_valid |-> !en_256);

  assert_code_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_valid && $past(clk_valid)) |-> $stable(ratio_code));

  assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_valid && ratio_code == 2'd0) |-> en_256);

  assert_two_of_three_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_valid && ratio_code == 2'd1 && $past(en_256) && $past(en_256, 2)) |-> !en_256);

  assert_half_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_valid && $past(clk_valid) && ratio_code == 2'd2) |-> (en_256 != $past(en_256)));

  assert_third_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_valid && ratio_code == 2'd3 && ($past(en_256) || $past(en_256, 2))) |-> !en_256);

  assert_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gap >= 12'(TIMEOUT)) |-> !clk_valid);

endmodule

bind mclk_ratio_detect mcr_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pdn_n      (pdn_n),
  .frame_in   (frame_in),
  .ratio_code (ratio_code),
  .en_256     (en_256),
  .clk_valid  (clk_valid)
);

// File: tb/sim_mclk_ratio_detect.sv
`timescale 1ns/1ps
module sim_mclk_ratio_detect;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn_n = 1'b1;
  logic       frame_in = 1'b0;
  logic [1:0] ratio_code;
  logic       en_256;
  logic       clk_valid;

  int tests = 0;
  int fails = 0;
  int en_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mclk_ratio_detect u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdn_n      (pdn_n),
    .frame_in   (frame_in),
    .ratio_code (ratio_code),
    .en_256     (en_256),
    .clk_valid  (clk_valid)
  );

  // Behavioural reference model
  int m_gap = 0, m_last = -1, m_code = 0, m_ph = 0;
  bit m_fq = 0, m_seen = 0, m_valid = 0;
  int noms[$] = '{256, 384, 512, 768};

  function automatic int classify(int p);
    foreach (noms[k]) if (p >= noms[k] - 2 && p <= noms[k] + 2) return k;
    return -1;
  endfunction

  function automatic int plen(int c);
    return (c == 0) ? 1 : (c == 2) ? 2 : 3;
  endfunction

  function automatic bit pat(int c, int ph);
    case (c)
      0: return 1'b1;
      1: return ph != 2;
      default: return ph == 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit e, ov;
    int oc, p, c;
    ov = m_valid;
    oc = m_code;
    e  = frame_in && !m_fq;
    if (!rst_n) begin
      m_fq = 0; m_gap = 0; m_last = -1; m_code = 0; m_ph = 0; m_seen = 0; m_valid = 0;
    end else begin
      m_fq = frame_in;
      if (!pdn_n) begin
        m_gap = 0; m_last = -1; m_code = 0; m_ph = 0; m_seen = 0; m_valid = 0;
      end else begin
        m_ph = ov ? (m_ph + 1) % plen(oc) : 0;
        if (e) begin
          if (m_seen) begin
            p = m_gap + 1;
            c = classify(p);
            if (c >= 0 && c == m_last) begin
              m_valid = 1; m_code = c;
            end else m_valid = 0;
            m_last = c;
          end
          m_seen = 1; m_gap = 0;
        end else if (m_gap == 1023) begin
          m_valid = 0; m_last = -1; m_seen = 0;
        end else m_gap++;
      end
    end
    #1;
    if (rst_n && !done) begin
      check("R11 model valid", clk_valid, m_valid);
      check("R11 model en", en_256, m_valid && pat(m_code, m_ph));
      if (m_valid) check("R3 model code", ratio_code, m_code);
      if (en_256) en_cnt++;
    end
  end

  task automatic frames(int per, int hi, int n);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < per; i++) begin
        @(negedge clk);
        frame_in = (i < hi);
      end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rate_case(int per, int hi, int code, string tag);
    frames(per, hi, 4);
    check({tag, " locked"}, clk_valid, 1);
    check({tag, " code"}, ratio_code, code);
    en_cnt = 0;
    frames(per, hi, 1);
    check({tag, " strobes per frame"}, en_cnt, 256);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 reset valid", clk_valid, 0);
    check("R1 reset en", en_256, 0);
    check("R1 reset code", ratio_code, 0);
    rst_n = 1'b1;
    idle(5);
    check("R1 idle valid", clk_valid, 0);

    // R4: two frames -> not yet, third edge locks
    frames(256, 128, 2);
    check("R4 before lock", clk_valid, 0);
    @(negedge clk); frame_in = 1'b1;
    @(negedge clk);
    check("R4 lock after edge", clk_valid, 1);
    frames(256, 128, 2);

    rate_case(256, 128, 0, "R6");
    rate_case(384, 10, 1, "R7 R12");
    rate_case(512, 500, 2, "R8 R12");
    rate_case(768, 1, 3, "R9 R12");

    // R3 window edges
    frames(514, 200, 4);
    check("R3 +2 window valid", clk_valid, 1);
    check("R3 +2 window code", ratio_code, 2);
    frames(766, 300, 4);
    check("R3 -2 window code", ratio_code, 3);
    frames(259, 100, 5);
    check("R3 out of window", clk_valid, 0);

    // R5 class change
    frames(256, 128, 4);
    check("R5 pre lock", clk_valid, 1);
    frames(512, 100, 1);
    frames(256, 128, 1);
    check("R5 drop on change", clk_valid, 0);

    // R10 timeout
    frames(256, 128, 4);
    idle(1100);
    check("R10 timeout drop", clk_valid, 0);
    frames(256, 128, 2);
    check("R10 restart needs three edges", clk_valid, 0);
    frames(256, 128, 1);
    check("R10 relock", clk_valid, 1);

    // R2 power-down
    frames(256, 128, 2);
    @(negedge clk); pdn_n = 1'b0;
    @(negedge clk);
    check("R2 pdn valid", clk_valid, 0);
    check("R2 pdn en", en_256, 0);
    pdn_n = 1'b1;
    frames(256, 128, 2);
    check("R2 history dropped", clk_valid, 0);
    frames(256, 128, 1);
    check("R2 relock", clk_valid, 1);

    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule